// File: doc/BRIEF.md
# Dual-Bank Write Status Reporter

This block models the read side of a two-bank nonvolatile memory while an internal program or erase cycle runs. A host starts an operation on one bank: a word program, a sector erase or a whole-bank erase. From then on that bank is busy for a fixed number of clock cycles, and the number depends on the kind of operation. The host learns that the operation has finished by reading the busy bank.

While a bank is busy, a read from it returns a status word instead of array data. Bit 7 is the inverse of bit 7 of the last word loaded into that bank. Bit 6 changes value on every read of that bank. All other bits are the last loaded word unchanged. The other bank keeps returning normal array data.

Once a cycle has started, nothing can end it early. This includes the reset input and new operation requests. The array itself is a register model. It powers up erased (all ones), and reset does not clear it.

Top module: `wsr_dual_bank`

## Requirements
- R1: A program operation (op_kind 0) on an idle bank writes op_data at op_addr. It raises that bank's bank_busy in the cycle after acceptance and holds it high for exactly PROG_CYC cycles. Once busy has ended, a read of op_addr returns op_data.
- R2: Every read from a busy bank, at any address, returns in bit 7 the inverse of bit 7 of the last word loaded into that bank.
- R3: Bit 6 of reads from a busy bank reads 0 on the first read after the operation starts (or after reset), then alternates on each later read of that bank. Reads of the other bank do not advance it.
- R4: During busy, bits 15..8 and 5..0 of a read equal the same bits of the last loaded word. For an erase, the last loaded word is all ones.
- R5: After busy ends, bits 7 and 6 return the true stored data, so two successive reads return equal bit 6.
- R6: Reads of a bank that is not busy return its array contents, even while the other bank is busy.
- R7: A sector erase (op_kind 1) sets to all ones every word whose address bits above the low SECT_W bits match op_addr. Other words stay unchanged. Busy lasts SECT_CYC cycles.
- R8: A bank erase (op_kind 2) sets every word of the bank to all ones. Busy lasts BLOCK_CYC cycles, the longest interval.
- R9: An operation request to a bank that is already busy is ignored. It changes neither the array nor the busy length.
- R10: Asserting rst during busy neither shortens nor extends the busy interval. After reset, rd_valid and rd_data are 0. At power-up no bank is busy and the array reads all ones.
- R11: rd_valid is high in the cycle after each rd_en, with rd_data valid in that same cycle. rd_data holds its value when there is no read. op_kind 3 is reserved and is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request strobe |
| op_bank | input | 1 | Target bank of the operation |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 bank erase, 3 reserved |
| op_addr | input | ADDR_W | Word address of the operation |
| op_data | input | 16 | Word to program |
| rd_en | input | 1 | Read strobe, one read per cycle high |
| rd_bank | input | 1 | Bank to read |
| rd_addr | input | ADDR_W | Word address to read |
| rd_data | output | 16 | Read result, array data or status word |
| rd_valid | output | 1 | rd_data holds a new read result |
| bank_busy | output | 2 | Per-bank internal cycle in progress |

## Verification
Suppose the per-bank toggle flop or busy counter held a wrong value. The next read of that bank would show it: bit 6 would break its alternation, or bit 7 would turn true before or after the programmed number of cycles. Any of these shows up at rd_data one cycle after the read strobe. Corrupted array or last-loaded state shows up in the other status bits or in the post-completion read. A shortened or stretched busy interval shows up at bank_busy and is measured against the cycle count for each kind of operation.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

    localparam int WORD_W  = 16;
    localparam int INV_BIT = 7;
    localparam int TGL_BIT = 6;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_PROG        = 2'd0,
        OP_SECT_ERASE  = 2'd1,
        OP_BANK_ERASE  = 2'd2,
        OP_RSVD        = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic     go;
        op_kind_e kind;
        word_t    data;
    } op_req_t;

    function automatic word_t poll_word(input word_t last, input logic tgl);
        word_t w;
        w          = last;
        w[INV_BIT] = ~last[INV_BIT];
        w[TGL_BIT] = tgl;
        return w;
    endfunction

    function automatic logic kind_legal(input op_kind_e k);
        return k != OP_RSVD;
    endfunction

endpackage

// File: rtl/wsr_op_timer.sv
module wsr_op_timer
    import wsr_pkg::*;
#(
    parameter int CNT_W     = 7,
    parameter int PROG_CYC  = 8,
    parameter int SECT_CYC  = 40,
    parameter int BLOCK_CYC = 120
) (
    input  logic     clk,
    input  logic     start,
    input  op_kind_e kind,
    output logic     busy
);
    // Power-up value only: no reset input, so no cycle can be cut short.
    logic [CNT_W-1:0] cnt_q  = '0;
    logic             busy_q = 1'b0;
    logic [CNT_W-1:0] load;

    always_comb begin
        unique case (kind)
            OP_SECT_ERASE: load = CNT_W'(SECT_CYC);
            OP_BANK_ERASE: load = CNT_W'(BLOCK_CYC);
            default:       load = CNT_W'(PROG_CYC);
        endcase
    end

    always_ff @(posedge clk) begin
        if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= load;
        end else if (busy_q) begin
            if (cnt_q == CNT_W'(1)) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy = busy_q;

endmodule

// File: rtl/wsr_bank_array.sv
module wsr_bank_array
    import wsr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              start,
    input  op_req_t           req,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output word_t             rd_word,
    output word_t             last_word
);
    localparam int DEPTH = 1 << ADDR_W;

    // Nonvolatile model: erased at power-up, untouched by reset.
    word_t mem [DEPTH] = '{default: '1};
    word_t last_q      = '0;

    always_ff @(posedge clk) begin
        if (start) begin
            unique case (req.kind)
                OP_PROG: begin
                    mem[op_addr] <= req.data;
                    last_q       <= req.data;
                end
                OP_SECT_ERASE: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if ((ADDR_W'(i) >> SECT_W) == (op_addr >> SECT_W))
                            mem[i] <= '1;
                    end
                    last_q <= '1;
                end
                default: begin
                    for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
                    last_q <= '1;
                end
            endcase
        end
    end

    assign rd_word   = mem[rd_addr];
    assign last_word = last_q;

endmodule

// File: rtl/wsr_poll_status.sv
module wsr_poll_status
    import wsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  rd_hit,
    input  logic  busy,
    input  word_t last_word,
    input  word_t arr_word,
    output word_t out_word
);
    logic tgl_q;

    always_ff @(posedge clk) begin
        if (rst || start)       tgl_q <= 1'b0;
        else if (rd_hit && busy) tgl_q <= ~tgl_q;
    end

    assign out_word = busy ? poll_word(last_word, tgl_q) : arr_word;

endmodule

// File: rtl/wsr_dual_bank.sv
module wsr_dual_bank
    import wsr_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int SECT_W    = 3,
    parameter int PROG_CYC  = 8,
    parameter int SECT_CYC  = 40,
    parameter int BLOCK_CYC = 120
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              op_bank,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [15:0]       op_data,
    input  logic              rd_en,
    input  logic              rd_bank,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data,
    output logic              rd_valid,
    output logic [1:0]        bank_busy
);
    localparam int NBANK = 2;
    localparam int CNT_W = $clog2(BLOCK_CYC + 1);

    op_req_t req;
    word_t   bank_word [NBANK];
    word_t   arr_word  [NBANK];
    word_t   last_word [NBANK];
    logic    start     [NBANK];
    logic    rd_hit    [NBANK];

    always_comb begin
        req.go   = op_valid && !rst && kind_legal(op_kind_e'(op_kind));
        req.kind = op_kind_e'(op_kind);
        req.data = op_data;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // A busy bank accepts nothing: no abort, no restart.
        assign start[b]  = req.go && (op_bank == 1'(b)) && !bank_busy[b];
        assign rd_hit[b] = rd_en && !rst && (rd_bank == 1'(b));

        wsr_op_timer #(
            .CNT_W    (CNT_W),
            .PROG_CYC (PROG_CYC),
            .SECT_CYC (SECT_CYC),
            .BLOCK_CYC(BLOCK_CYC)
        ) u_timer (
            .clk  (clk),
            .start(start[b]),
            .kind (req.kind),
            .busy (bank_busy[b])
        );

        wsr_bank_array #(
            .ADDR_W(ADDR_W),
            .SECT_W(SECT_W)
        ) u_array (
            .clk      (clk),
            .start    (start[b]),
            .req      (req),
            .op_addr  (op_addr),
            .rd_addr  (rd_addr),
            .rd_word  (arr_word[b]),
            .last_word(last_word[b])
        );

        wsr_poll_status u_status (
            .clk      (clk),
            .rst      (rst),
            .start    (start[b]),
            .rd_hit   (rd_hit[b]),
            .busy     (bank_busy[b]),
            .last_word(last_word[b]),
            .arr_word (arr_word[b]),
            .out_word (bank_word[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= bank_word[rd_bank];
        end
    end

endmodule

// File: rtl/wsr_chk.sv
module wsr_chk #(
    parameter int CNT_W     = 7,
    parameter int PROG_CYC  = 8,
    parameter int SECT_CYC  = 40,
    parameter int BLOCK_CYC = 120
) (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic        op_bank,
    input logic        rd_en,
    input logic        rd_bank,
    input logic [15:0] rd_data,
    input logic        rd_valid,
    input logic [1:0]  bank_busy,
    input logic [15:0] last0,
    input logic [15:0] last1
);
    logic [CNT_W-1:0] run0 = '0;
    logic [CNT_W-1:0] run1 = '0;

    always_ff @(posedge clk) begin
        run0 <= bank_busy[0] ? run0 + 1'b1 : '0;
        run1 <= bank_busy[1] ? run1 + 1'b1 : '0;
    end

    // R1 R7 R8 R9 R10
    busy0_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bank_busy[0]) |-> (run0 == CNT_W'(PROG_CYC) || run0 == CNT_W'(SECT_CYC)
                                 || run0 == CNT_W'(BLOCK_CYC)));

    // R1 R7 R8 R9 R10
    busy1_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bank_busy[1]) |-> (run1 == CNT_W'(PROG_CYC) || run1 == CNT_W'(SECT_CYC)
                                 || run1 == CNT_W'(BLOCK_CYC)));

    // R1
    busy0_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bank_busy[0]) |-> $past(op_valid && !op_bank));

    // R1
    busy1_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bank_busy[1]) |-> $past(op_valid && op_bank));

    // R2
    inv_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && bank_busy[rd_bank]) |=> rd_data[7] != $past(rd_bank ? last1[7] : last0[7]));

    // R11
    rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (!rd_valid && $stable(rd_data)));

endmodule

bind wsr_dual_bank wsr_chk #(
    .CNT_W    (CNT_W),
    .PROG_CYC (PROG_CYC),
    .SECT_CYC (SECT_CYC),
    .BLOCK_CYC(BLOCK_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_bank  (op_bank),
    .rd_en    (rd_en),
    .rd_bank  (rd_bank),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .bank_busy(bank_busy),
    .last0    (last_word[0]),
    .last1    (last_word[1])
);

// File: tb/tb_wsr_dual_bank.sv
module tb_wsr_dual_bank;
    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int SECT_W = 3;
    localparam int PCYC   = 8;
    localparam int SCYC   = 40;
    localparam int BCYC   = 120;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              op_valid = 1'b0;
    logic              op_bank  = 1'b0;
    logic [1:0]        op_kind  = 2'd0;
    logic [ADDR_W-1:0] op_addr  = '0;
    logic [15:0]       op_data  = '0;
    logic              rd_en    = 1'b0;
    logic              rd_bank  = 1'b0;
    logic [ADDR_W-1:0] rd_addr  = '0;
    logic [15:0]       rd_data;
    logic              rd_valid;
    logic [1:0]        bank_busy;

    wsr_dual_bank #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PCYC),
                    .SECT_CYC(SCYC), .BLOCK_CYC(BCYC)) dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_bank(op_bank),
        .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
        .rd_en(rd_en), .rd_bank(rd_bank), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid), .bank_busy(bank_busy));

    always #5 clk = ~clk;

    typedef struct packed {
        logic              bank;
        logic [1:0]        kind;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       data;
        logic [7:0]        cyc;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 2'd0, 6'd5,  16'h1234, 8'(PCYC)},
        '{1'b1, 2'd0, 6'd9,  16'hA5C3, 8'(PCYC)},
        '{1'b0, 2'd0, 6'd12, 16'h00FF, 8'(PCYC)},
        '{1'b0, 2'd1, 6'd5,  16'h0000, 8'(SCYC)},
        '{1'b1, 2'd2, 6'd9,  16'h0000, 8'(BCYC)},
        '{1'b1, 2'd0, 6'd63, 16'h7E81, 8'(PCYC)}
    };

    logic [15:0] model [2][DEPTH];
    logic [15:0] last  [2];
    logic        tgl   [2];
    int          run   [2];
    int          len   [2];
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;

    always @(negedge clk) begin
        for (int b = 0; b < 2; b++) begin
            if (bank_busy[b] === 1'b1) run[b]++;
            else if (run[b] != 0) begin len[b] = run[b]; run[b] = 0; end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic start_op(input logic b, input logic [1:0] k,
                            input logic [ADDR_W-1:0] a, input logic [15:0] d);
        bit idle;
        @(negedge clk);
        idle = (bank_busy[b] == 1'b0);
        op_valid = 1'b1; op_bank = b; op_kind = k; op_addr = a; op_data = d;
        @(negedge clk);
        op_valid = 1'b0;
        if (idle && !rst && k != 2'd3) begin
            tgl[b] = 1'b0;
            len[b] = 0;
            if (k == 2'd0) begin
                model[b][a] = d; last[b] = d;
            end else begin
                for (int i = 0; i < DEPTH; i++)
                    if (k == 2'd2 || (i >> SECT_W) == (int'(a) >> SECT_W))
                        model[b][i] = 16'hFFFF;
                last[b] = 16'hFFFF;
            end
        end
    endtask

    // One read; compares against the model and returns the data.
    task automatic rd_chk(input logic b, input logic [ADDR_W-1:0] a,
                          input string req, output logic [15:0] d);
        bit busy_now;
        logic [15:0] exp;
        @(negedge clk);
        busy_now = bank_busy[b];
        rd_en = 1'b1; rd_bank = b; rd_addr = a;
        @(negedge clk);
        d = rd_data;
        rd_en = 1'b0;
        if (busy_now) begin
            exp = last[b];
            exp[7] = ~last[b][7];
            exp[6] = tgl[b];
            tgl[b] = ~tgl[b];
        end else begin
            exp = model[b][a];
        end
        chk(rd_valid === 1'b1, "R11 rd_valid", int'(rd_valid), 1);
        chk(d === exp, req, int'(d), int'(exp));
    endtask

    task automatic poll(input logic b, input logic [ADDR_W-1:0] a, input string req);
        logic [15:0] d;
        int prev6 = -1;
        for (int n = 0; n < 400; n++) begin
            rd_chk(b, a, req, d);
            if (d[7] == model[b][a][7] && prev6 == int'(d[6])) break;
            prev6 = int'(d[6]);
        end
    endtask

    initial begin
        logic [15:0] d;
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < DEPTH; i++) model[b][i] = 16'hFFFF;
            last[b] = '0; tgl[b] = 1'b0; run[b] = 0; len[b] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset and power-up state
        chk(rd_valid === 1'b0, "R10 rd_valid after reset", int'(rd_valid), 0);
        chk(rd_data === 16'h0, "R10 rd_data after reset", int'(rd_data), 0);
        chk(bank_busy === 2'b00, "R10 busy at power-up", int'(bank_busy), 0);
        rd_chk(1'b0, 6'd0, "R10 erased at power-up", d);
        @(negedge clk);
        chk(rd_valid === 1'b0 && rd_data === 16'hFFFF, "R11 hold without read",
            int'(rd_data), 16'hFFFF);

        // Table walk: R1 R2 R3 R4 R5 R7 R8
        for (int v = 0; v < 6; v++) begin
            start_op(VEC[v].bank, VEC[v].kind, VEC[v].addr, VEC[v].data);
            poll(VEC[v].bank, VEC[v].addr, "R2 R3 R4 R5 poll word");
            chk(len[VEC[v].bank] == int'(VEC[v].cyc), "R1 R7 R8 busy length",
                len[VEC[v].bank], int'(VEC[v].cyc));
        end
        rd_chk(1'b0, 6'd12, "R7 word outside sector kept", d);
        rd_chk(1'b0, 6'd5,  "R7 word inside sector erased", d);
        rd_chk(1'b1, 6'd9,  "R8 bank erase clears word", d);

        // R6, R3 other-bank reads, R9 ignored op during busy
        start_op(1'b0, 2'd2, 6'd0, 16'h0);
        rd_chk(1'b1, 6'd63, "R6 other bank normal read", d);
        rd_chk(1'b0, 6'd3,  "R3 first busy read bit6 0", d);
        chk(d[6] === 1'b0, "R3 first toggle value", int'(d[6]), 0);
        rd_chk(1'b1, 6'd63, "R6 other bank read again", d);
        rd_chk(1'b0, 6'd40, "R3 toggle not advanced by other bank", d);
        chk(d[6] === 1'b1, "R3 second toggle value", int'(d[6]), 1);
        start_op(1'b0, 2'd0, 6'd0, 16'h0000);
        poll(1'b0, 6'd0, "R9 poll after ignored op");
        chk(len[0] == BCYC, "R9 busy length unchanged", len[0], BCYC);
        rd_chk(1'b0, 6'd0, "R9 ignored program left word erased", d);
        chk(d === 16'hFFFF, "R9 word value", int'(d), 16'hFFFF);

        // R10 reset during busy
        start_op(1'b1, 2'd1, 6'd60, 16'h0);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        tgl[1] = 1'b0;
        repeat (3) @(negedge clk);
        chk(bank_busy[1] === 1'b1, "R10 busy held in reset", int'(bank_busy[1]), 1);
        rst = 1'b0;
        poll(1'b1, 6'd63, "R10 poll after reset");
        chk(len[1] == SCYC, "R10 busy length with reset", len[1], SCYC);
        rd_chk(1'b1, 6'd55, "R7 neighbour sector kept", d);

        // R11 reserved kind ignored
        start_op(1'b0, 2'd3, 6'd2, 16'h0);
        @(negedge clk);
        chk(bank_busy[0] === 1'b0, "R11 reserved kind no busy", int'(bank_busy[0]), 0);
        rd_chk(1'b0, 6'd2, "R11 reserved kind no write", d);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule